// File: doc/BRIEF.md
# External Bus Write Posting Slice

This slice sits between a single bus master (CPU or DMA) and two targets: a multi-state external memory bus and a single-cycle internal bus for on-chip memory and I/O registers. When posting is enabled, an external write or a single-address DMA transfer is captured into a one-entry buffer. The master is released in the same cycle. The external cycle then runs on its own, and an internal access issued behind it can complete while the external cycle is still in progress.

The master presents `m_req_i` with a target class (internal, external or single-address DMA) and holds it until `m_rdy_o` is high in the same cycle. An external cycle lasts `1 + wait_cnt_i` states, and it begins in the cycle after the request is accepted. An internal access may overlap a posted external cycle only from that cycle's second state onward. Any cycle in which no external state is running is an idle cycle, and the slice drives defined pin levels during idle cycles.

Top module: `xbus_wbuf`

## Requirements
- R1: After reset, no external cycle runs: chip select, address strobe, read strobe, both write strobes and DMA acknowledge are high, and the data bus is not driven (`ext_dq_oe_o` = 0).
- R2: An accepted external access holds `ext_cs_no` and `ext_as_no` low for exactly `1 + wait_cnt_i` consecutive cycles, starting in the cycle after acceptance.
- R3: While `buf_en_i` = 1, an external write is accepted in the cycle it is requested if no external cycle is running. Its data then appears on `ext_dq_o` with `ext_dq_oe_o` = 1, and `ext_wr_no[b]` goes low only for bytes whose `m_be_i[b]` = 1. Bit 0 is the low byte.
- R4: While `buf_en_i` = 1, a single-address DMA transfer is also accepted at once. During its states `ext_dack_no` is low and the data bus is not driven.
- R5: An internal access issued behind a posted external cycle stalls during that cycle's first state. In every later state it completes in the same cycle (`m_rdy_o` = 1 and `int_req_o` = 1) while chip select is still low.
- R6: With `wait_cnt_i` = 0, no overlap occurs: the waiting internal access completes in the idle cycle that follows the single external state.
- R7: While `buf_en_i` = 0, an external write is not posted. `m_rdy_o` rises only in the last state of its cycle, and an internal access stalls until any running external cycle ends.
- R8: A new external access requested while an external cycle runs stalls. It is accepted in the first idle cycle afterwards.
- R9: An internal read that overlaps a posted write returns `int_rdata_i` on `m_rdata_o`, never the buffered write data.
- R10: In an idle cycle with an external request pending, `ext_addr_o` already shows that request's address and the data bus is undriven.
- R11: In idle, `ext_cas_no` is all ones. It is all zeros while `dram_ras_down_i` or `refresh_i` is 1.
- R12: An external read is never posted. `ext_rd_no` is low during its states, and `m_rdy_o` rises in the last state with `m_rdata_o` equal to `ext_dq_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| buf_en_i | input | 1 | Posting enable bit |
| wait_cnt_i | input | WW (2) | Wait states added to an external cycle |
| dram_ras_down_i | input | 1 | DRAM space kept in row-held mode |
| refresh_i | input | 1 | DRAM refresh cycle running |
| m_req_i | input | 1 | Master request |
| m_ext_i | input | 1 | Request targets external space |
| m_dma_i | input | 1 | Request is a single-address DMA transfer |
| m_we_i | input | 1 | Write (1) or read (0) |
| m_addr_i | input | AW (24) | Master address |
| m_wdata_i | input | DW (16) | Master write data |
| m_be_i | input | NB (2) | Byte enables |
| m_rdy_o | output | 1 | Access completes this cycle |
| m_rdata_o | output | DW (16) | Read data to master |
| int_req_o | output | 1 | Internal access strobe |
| int_we_o | output | 1 | Internal write |
| int_addr_o | output | AW (24) | Internal address |
| int_wdata_o | output | DW (16) | Internal write data |
| int_be_o | output | NB (2) | Internal byte enables |
| int_rdata_i | input | DW (16) | Internal read data, same cycle |
| ext_addr_o | output | AW (24) | External address bus |
| ext_dq_o | output | DW (16) | External data out |
| ext_dq_oe_o | output | 1 | External data output enable |
| ext_dq_i | input | DW (16) | External data in |
| ext_cs_no | output | 1 | Chip select, active low |
| ext_as_no | output | 1 | Address strobe, active low |
| ext_rd_no | output | 1 | Read strobe, active low |
| ext_wr_no | output | NB (2) | Per-byte write strobes, active low |
| ext_cas_no | output | NB (2) | Column strobes, active low |
| ext_dack_no | output | 1 | DMA acknowledge, active low |

## Verification
The assertions assume a master with at most one outstanding request, which it holds stable until `m_rdy_o` is high. Without that assumption, the rules about stalls in the first state and about buffer capture cannot be checked. The directed tasks always keep a request and its attributes unchanged until they have observed ready, and each task ends with idle cycles. As a result, no task begins while an external cycle from an earlier task is still running. `buf_en_i` changes only between scenarios or in a cycle with no external acceptance, so the posted flag always reflects the setting that was in force at capture.

// File: rtl/xbus_wbuf_pkg.sv
package xbus_wbuf_pkg;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_INT,
    ACC_EXT,
    ACC_DMA
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic req, input logic ext, input logic dma);
    if (!req) return ACC_NONE;
    if (dma) return ACC_DMA;
    if (ext) return ACC_EXT;
    return ACC_INT;
  endfunction

endpackage

// File: rtl/xbus_wbuf_dec.sv
module xbus_wbuf_dec
  import xbus_wbuf_pkg::*;
#(
  parameter int WW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  acc_kind_e     kind_i,
  input  logic          we_i,
  input  logic          buf_en_i,
  input  logic          busy_i,
  input  logic          posted_i,
  input  logic [WW-1:0] st_i,
  input  logic          last_i,
  output logic          rdy_o,
  output logic          cap_o,
  output logic          post_o,
  output logic          int_fire_o,
  output logic          rsel_ext_o
);

  logic ext_like, int_ok;

  assign ext_like   = (kind_i == ACC_EXT) || (kind_i == ACC_DMA);
  assign post_o     = buf_en_i && ((kind_i == ACC_DMA) || (kind_i == ACC_EXT && we_i));
  // overlap only behind a posted cycle, never in its first state
  assign int_ok     = !busy_i || (buf_en_i && posted_i && (st_i != '0));
  assign int_fire_o = (kind_i == ACC_INT) && int_ok;
  assign cap_o      = ext_like && !busy_i;
  assign rsel_ext_o = ext_like;
  assign rdy_o      = int_fire_o || (cap_o && post_o) || (ext_like && busy_i && !posted_i && last_i);

  // R5
  first_state_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_fire_o && busy_i) |-> (st_i != '0));

  // R7
  no_overlap_unposted_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_fire_o && busy_i) |-> (posted_i && buf_en_i));

endmodule

// File: rtl/xbus_wbuf_seq.sv
module xbus_wbuf_seq #(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int WW = 2,
  localparam int NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          post_i,
  input  logic [WW-1:0] wait_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic [NB-1:0] be_i,
  input  logic          we_i,
  input  logic          dma_i,
  output logic          busy_o,
  output logic          posted_o,
  output logic [WW-1:0] st_o,
  output logic          last_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o,
  output logic [NB-1:0] be_o,
  output logic          we_o,
  output logic          dma_o
);

  logic          busy_q, posted_q, we_q, dma_q;
  logic [WW-1:0] st_q, len_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [NB-1:0] be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      posted_q <= 1'b0;
      st_q     <= '0;
      len_q    <= '0;
      addr_q   <= '0;
      data_q   <= '0;
      be_q     <= '0;
      we_q     <= 1'b0;
      dma_q    <= 1'b0;
    end else if (cap_i) begin
      busy_q   <= 1'b1;
      posted_q <= post_i;
      st_q     <= '0;
      len_q    <= wait_i;
      addr_q   <= addr_i;
      data_q   <= data_i;
      be_q     <= be_i;
      we_q     <= we_i;
      dma_q    <= dma_i;
    end else if (busy_q) begin
      if (st_q == len_q) busy_q <= 1'b0;
      else               st_q   <= st_q + 1'b1;
    end
  end

  assign busy_o   = busy_q;
  assign posted_o = posted_q;
  assign st_o     = st_q;
  assign last_o   = busy_q && (st_q == len_q);
  assign addr_o   = addr_q;
  assign data_o   = data_q;
  assign be_o     = be_q;
  assign we_o     = we_q;
  assign dma_o    = dma_q;

  // R2
  cycle_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && st_q == len_q && !cap_i) |=> !busy_q);

  // R8
  cap_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |-> !busy_q);

  // R3
  entry_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && st_q != len_q) |=> ($stable(addr_q) && $stable(data_q) && $stable(be_q)));

endmodule

// File: rtl/xbus_wbuf_pins.sv
module xbus_wbuf_pins #(
  parameter int NB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          active_i,
  input  logic          we_i,
  input  logic          dma_i,
  input  logic [NB-1:0] be_i,
  input  logic          ras_down_i,
  input  logic          refresh_i,
  output logic          cs_no,
  output logic          as_no,
  output logic          rd_no,
  output logic [NB-1:0] wr_no,
  output logic [NB-1:0] cas_no,
  output logic          dack_no,
  output logic          dq_oe_o
);

  assign cs_no   = !active_i;
  assign as_no   = !active_i;
  assign rd_no   = !(active_i && !we_i);
  assign dack_no = !(active_i && dma_i);
  assign dq_oe_o = active_i && we_i && !dma_i;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign wr_no[b]  = !(active_i && we_i && be_i[b]);
    assign cas_no[b] = !(ras_down_i || refresh_i);
  end

  // R10
  idle_pins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> (cs_no && as_no && rd_no && (&wr_no) && dack_no && !dq_oe_o));

  // R4
  dma_float_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dack_no |-> !dq_oe_o);

endmodule

// File: rtl/xbus_wbuf.sv
module xbus_wbuf
  import xbus_wbuf_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int WW = 2,
  localparam int NB = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          buf_en_i,
  input  logic [WW-1:0] wait_cnt_i,
  input  logic          dram_ras_down_i,
  input  logic          refresh_i,
  input  logic          m_req_i,
  input  logic          m_ext_i,
  input  logic          m_dma_i,
  input  logic          m_we_i,
  input  logic [AW-1:0] m_addr_i,
  input  logic [DW-1:0] m_wdata_i,
  input  logic [NB-1:0] m_be_i,
  output logic          m_rdy_o,
  output logic [DW-1:0] m_rdata_o,
  output logic          int_req_o,
  output logic          int_we_o,
  output logic [AW-1:0] int_addr_o,
  output logic [DW-1:0] int_wdata_o,
  output logic [NB-1:0] int_be_o,
  input  logic [DW-1:0] int_rdata_i,
  output logic [AW-1:0] ext_addr_o,
  output logic [DW-1:0] ext_dq_o,
  output logic          ext_dq_oe_o,
  input  logic [DW-1:0] ext_dq_i,
  output logic          ext_cs_no,
  output logic          ext_as_no,
  output logic          ext_rd_no,
  output logic [NB-1:0] ext_wr_no,
  output logic [NB-1:0] ext_cas_no,
  output logic          ext_dack_no
);

  acc_kind_e     kind;
  logic          cap, post, int_fire, rsel_ext;
  logic          busy, posted, last, b_we, b_dma;
  logic [WW-1:0] st;
  logic [AW-1:0] b_addr;
  logic [NB-1:0] b_be;

  assign kind = classify(m_req_i, m_ext_i, m_dma_i);

  xbus_wbuf_dec #(.WW(WW)) u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .kind_i     (kind),
    .we_i       (m_we_i),
    .buf_en_i   (buf_en_i),
    .busy_i     (busy),
    .posted_i   (posted),
    .st_i       (st),
    .last_i     (last),
    .rdy_o      (m_rdy_o),
    .cap_o      (cap),
    .post_o     (post),
    .int_fire_o (int_fire),
    .rsel_ext_o (rsel_ext)
  );

  xbus_wbuf_seq #(.AW(AW), .DW(DW), .WW(WW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap),
    .post_i   (post),
    .wait_i   (wait_cnt_i),
    .addr_i   (m_addr_i),
    .data_i   (m_wdata_i),
    .be_i     (m_be_i),
    .we_i     (m_we_i),
    .dma_i    (m_dma_i),
    .busy_o   (busy),
    .posted_o (posted),
    .st_o     (st),
    .last_o   (last),
    .addr_o   (b_addr),
    .data_o   (ext_dq_o),
    .be_o     (b_be),
    .we_o     (b_we),
    .dma_o    (b_dma)
  );

  xbus_wbuf_pins #(.NB(NB)) u_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (busy),
    .we_i       (b_we),
    .dma_i      (b_dma),
    .be_i       (b_be),
    .ras_down_i (dram_ras_down_i),
    .refresh_i  (refresh_i),
    .cs_no      (ext_cs_no),
    .as_no      (ext_as_no),
    .rd_no      (ext_rd_no),
    .wr_no      (ext_wr_no),
    .cas_no     (ext_cas_no),
    .dack_no    (ext_dack_no),
    .dq_oe_o    (ext_dq_oe_o)
  );

  // idle: present the next external cycle's address early
  assign ext_addr_o  = (!busy && rsel_ext) ? m_addr_i : b_addr;

  assign int_req_o   = int_fire;
  assign int_we_o    = m_we_i;
  assign int_addr_o  = m_addr_i;
  assign int_wdata_o = m_wdata_i;
  assign int_be_o    = m_be_i;
  assign m_rdata_o   = rsel_ext ? ext_dq_i : int_rdata_i;

endmodule

// File: tb/xbus_wbuf_tb.sv
module xbus_wbuf_tb;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int WW = 2;
  localparam int NB = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          buf_en = 1'b1;
  logic [WW-1:0] wait_cnt = '0;
  logic          ras_down = 1'b0, refresh = 1'b0;
  logic          m_req = 1'b0, m_ext = 1'b0, m_dma = 1'b0, m_we = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0;
  logic [NB-1:0] m_be = '1;
  logic          m_rdy;
  logic [DW-1:0] m_rdata;
  logic          int_req, int_we;
  logic [AW-1:0] int_addr;
  logic [DW-1:0] int_wdata;
  logic [NB-1:0] int_be;
  logic [DW-1:0] int_rdata = '0;
  logic [AW-1:0] ext_addr;
  logic [DW-1:0] ext_dq;
  logic          ext_dq_oe;
  logic [DW-1:0] ext_dq_in = '0;
  logic          cs_n, as_n, rd_n, dack_n;
  logic [NB-1:0] wr_n, cas_n;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  xbus_wbuf #(.AW(AW), .DW(DW), .WW(WW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .buf_en_i(buf_en), .wait_cnt_i(wait_cnt),
    .dram_ras_down_i(ras_down), .refresh_i(refresh),
    .m_req_i(m_req), .m_ext_i(m_ext), .m_dma_i(m_dma), .m_we_i(m_we),
    .m_addr_i(m_addr), .m_wdata_i(m_wdata), .m_be_i(m_be),
    .m_rdy_o(m_rdy), .m_rdata_o(m_rdata),
    .int_req_o(int_req), .int_we_o(int_we), .int_addr_o(int_addr),
    .int_wdata_o(int_wdata), .int_be_o(int_be), .int_rdata_i(int_rdata),
    .ext_addr_o(ext_addr), .ext_dq_o(ext_dq), .ext_dq_oe_o(ext_dq_oe), .ext_dq_i(ext_dq_in),
    .ext_cs_no(cs_n), .ext_as_no(as_n), .ext_rd_no(rd_n), .ext_wr_no(wr_n),
    .ext_cas_no(cas_n), .ext_dack_no(dack_n)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic drive_none();
    m_req = 0; m_ext = 0; m_dma = 0; m_we = 0;
  endtask

  task automatic drive_ext(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [NB-1:0] be);
    m_req = 1; m_ext = 1; m_dma = 0; m_we = we; m_addr = a; m_wdata = d; m_be = be;
  endtask

  task automatic drive_int(input logic we, input logic [AW-1:0] a);
    m_req = 1; m_ext = 0; m_dma = 0; m_we = we; m_addr = a; m_wdata = 16'h0C0C; m_be = '1;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) begin cyc(); drive_none(); end
  endtask

  task automatic t_reset();
    settle();
    chk("R1 cs in reset", cs_n, 1);
    chk("R1 oe in reset", ext_dq_oe, 0);
    cyc(); rst_n = 1; settle();
    chk("R1 cs", cs_n, 1);
    chk("R1 as", as_n, 1);
    chk("R1 rd", rd_n, 1);
    chk("R1 wr", wr_n, 2'b11);
    chk("R1 dack", dack_n, 1);
    chk("R1 oe", ext_dq_oe, 0);
  endtask

  task automatic t_overlap(input int w, input logic iwe);
    int lows;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    a = 24'h100000 + AW'(w);
    d = 16'hA500 + DW'(w);
    cyc(); buf_en = 1; wait_cnt = WW'(w); int_rdata = 16'hBEEF;
    drive_ext(1, a, d, 2'b01); settle();
    chk("R3 posted ready", m_rdy, 1);
    chk("R10 early addr", ext_addr, 32'(a));
    chk("R10 data undriven", ext_dq_oe, 0);
    cyc(); drive_int(iwe, 24'h000040); settle();
    chk("R5 first state stall", m_rdy, 0);
    chk("R2 cs state0", cs_n, 0);
    chk("R3 byte strobes", wr_n, 2'b10);
    chk("R3 data", ext_dq, 32'(d));
    chk("R3 oe", ext_dq_oe, 1);
    lows = 1;
    cyc(); settle();
    chk("R5 int completes", m_rdy, 1);
    chk("R5 int strobe", int_req, 1);
    if (w == 0) chk("R6 no overlap cs", cs_n, 1);
    else        chk("R5 overlapped cs", cs_n, 0);
    if (!iwe) chk("R9 int read data", m_rdata, 16'hBEEF);
    if (!cs_n) lows++;
    for (int i = 0; i < 5; i++) begin
      cyc(); drive_none(); settle();
      if (!cs_n) lows++;
    end
    chk("R2 cycle length", lows, w + 1);
  endtask

  task automatic t_dma();
    cyc(); buf_en = 1; wait_cnt = 1;
    m_req = 1; m_ext = 0; m_dma = 1; m_we = 1; m_addr = 24'h200000; settle();
    chk("R4 dma posted", m_rdy, 1);
    cyc(); drive_none(); settle();
    chk("R4 dack low", dack_n, 0);
    chk("R4 data undriven", ext_dq_oe, 0);
    cyc(); settle();
    chk("R4 dack second state", dack_n, 0);
    cyc(); settle();
    chk("R4 dack released", dack_n, 1);
    idle_n(1);
  endtask

  task automatic t_unposted();
    cyc(); buf_en = 0; wait_cnt = 1;
    drive_ext(1, 24'h300000, 16'h5A5A, 2'b11); settle();
    chk("R7 no early ready", m_rdy, 0);
    cyc(); settle();
    chk("R7 ready held state0", m_rdy, 0);
    cyc(); settle();
    chk("R7 ready in last state", m_rdy, 1);
    chk("R7 strobes", wr_n, 2'b00);
    cyc(); drive_none(); settle();
    chk("R7 cycle ended", cs_n, 1);
    // posted, then enable cleared: internal must wait
    cyc(); buf_en = 1; wait_cnt = 2;
    drive_ext(1, 24'h300010, 16'h1111, 2'b11); settle();
    chk("R3 posted", m_rdy, 1);
    cyc(); buf_en = 0; drive_int(1, 24'h000080); settle();
    cyc(); settle();
    chk("R7 int stalls state1", m_rdy, 0);
    cyc(); settle();
    chk("R7 int stalls last", m_rdy, 0);
    cyc(); settle();
    chk("R7 int after end", m_rdy, 1);
    cyc(); drive_none(); buf_en = 1;
    idle_n(1);
  endtask

  task automatic t_ext_read();
    cyc(); buf_en = 1; wait_cnt = 1; ext_dq_in = 16'h1234;
    drive_ext(0, 24'h400000, 16'h0, 2'b11); settle();
    chk("R12 read not posted", m_rdy, 0);
    cyc(); settle();
    chk("R12 rd low", rd_n, 0);
    chk("R12 ready held", m_rdy, 0);
    cyc(); settle();
    chk("R12 ready last", m_rdy, 1);
    chk("R12 read data", m_rdata, 16'h1234);
    idle_n(2);
  endtask

  task automatic t_b2b();
    cyc(); buf_en = 1; wait_cnt = 1;
    drive_ext(1, 24'h500000, 16'h2222, 2'b11); settle();
    chk("R3 first posted", m_rdy, 1);
    cyc(); drive_ext(1, 24'h500100, 16'h3333, 2'b11); settle();
    chk("R8 stall state0", m_rdy, 0);
    chk("R8 bus keeps first addr", ext_addr, 24'h500000);
    cyc(); settle();
    chk("R8 stall last", m_rdy, 0);
    cyc(); settle();
    chk("R8 accepted in idle", m_rdy, 1);
    chk("R10 idle cs", cs_n, 1);
    chk("R10 next addr shown", ext_addr, 24'h500100);
    cyc(); drive_none(); settle();
    chk("R8 second cycle", cs_n, 0);
    chk("R8 second data", ext_dq, 16'h3333);
    idle_n(3);
  endtask

  task automatic t_cas();
    cyc(); drive_none(); settle();
    chk("R11 idle cas high", cas_n, 2'b11);
    ras_down = 1; settle();
    chk("R11 row held", cas_n, 2'b00);
    ras_down = 0; refresh = 1; settle();
    chk("R11 refresh", cas_n, 2'b00);
    refresh = 0; settle();
    chk("R11 back high", cas_n, 2'b11);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    idle_n(2);
    for (int w = 0; w < 4; w++) t_overlap(w, 1'b1);
    t_overlap(2, 1'b0);
    t_dma();
    t_unposted();
    t_ext_read();
    t_b2b();
    t_cas();
    idle_n(2);
    finish_run();
  end

endmodule